// File: doc/BRIEF.md
# LPC Bus Transaction Monitor

A passive observer that sits beside a Low Pin Count bus and decodes target cycles (memory and I/O, read and write) from the frame strobe and the 4-bit multiplexed address/data lines. It samples only on rising edges of the bus clock and never drives anything. The monitor follows each cycle through its phases and reports three results, each with a one-clock strobe: the cycle kind, the address and the data byte. It also marks the final clock of a completed cycle.

Protocol problems raise one-clock warning pulses on a 7-bit vector. The monitor watches for:

- a start nibble that changes while the frame strobe is held low;
- reserved or unsupported start codes and cycle types;
- turnaround nibbles other than all-ones;
- bad SYNC codes and SYNC waits that go on too long;
- a frame strobe that reappears in the middle of a cycle.

DMA and bus-master traffic is not decoded. The monitor flags it as unsupported and goes back to idle.

Every output is registered. A result or warning caused by the nibble sampled at a rising edge is visible from just after that edge until the next one.

Top module: `lpc_txn_monitor`

## Requirements
- R1: After reset, cyc_valid, addr_valid, data_valid, done and all warn bits are 0.
- R2: With frame_n high, the monitor stays idle and ignores lad. A low frame_n while idle starts a cycle, and frame_n may stay low for several clocks. The nibble on the last low clock is the start code. Only code 0000 is decoded; any other code pulses warn[2] on the next clock (frame_n high) and returns to idle with no cyc_valid.
- R3: A start nibble that differs from the previous one while frame_n stays low pulses warn[0] on that clock.
- R4: The cycle-type nibble is sampled on the first clock with frame_n high. Bits [3:2] select the kind: 00 I/O, 01 memory, 10 DMA. Bit 1 set means write. When the kind is I/O or memory and bit 0 is 0, cyc_valid pulses, and cyc_mem and cyc_wr take bits 2 and 1.
- R5: A cycle-type nibble with bit 0 set, or with bits [3:2]=11, pulses warn[1]. A DMA kind (10) pulses warn[2]. Both return to idle.
- R6: The address is 4 nibbles for I/O and MEM_ADDR_NIBS (8) for memory, most significant nibble first. addr_valid pulses on the last nibble. An I/O address is zero-extended to 32 bits.
- R7: A read runs address, turnaround, SYNC, data, turnaround. A write runs address, data, turnaround, SYNC, turnaround. So data_valid comes 2 clocks after addr_valid for a write, and 5 + (wait nibbles) clocks after it for a read.
- R8: The data byte arrives as two nibbles, low nibble first. data_valid pulses with the full byte on the second nibble.
- R9: Each turnaround lasts two clocks. Any turnaround nibble other than 1111 pulses warn[3] on that clock, and decoding continues.
- R10: In SYNC, 0000 ends the phase, and 0101 and 0110 are wait codes. Any other value pulses warn[4] and returns to idle.
- R11: The SYNC_WAIT_LIMIT-th consecutive wait nibble (8 by default) pulses warn[5] and returns to idle. One fewer wait is accepted.
- R12: done pulses on the second clock of the final turnaround, 7 + (wait nibbles) clocks after addr_valid. The monitor is then idle.
- R13: frame_n low in the address, data, turnaround or SYNC phase pulses warn[6]. That nibble is taken as a new start field, and decoding restarts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| lclk | input | 1 | Bus clock; all sampling on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_n | input | 1 | Observed frame strobe, active low |
| lad | input | 4 | Observed address/data nibble lines |
| cyc_valid | output | 1 | One-clock strobe: cycle kind decoded |
| cyc_mem | output | 1 | Cycle kind is memory (0 = I/O) |
| cyc_wr | output | 1 | Cycle direction is write |
| addr_valid | output | 1 | One-clock strobe: address complete |
| addr | output | 32 | Decoded address (valid with addr_valid) |
| data_valid | output | 1 | One-clock strobe: data byte complete |
| data | output | 8 | Decoded data byte (valid with data_valid) |
| done | output | 1 | One-clock strobe on the last clock of a finished cycle |
| warn | output | 7 | Warning pulses; bit meanings given in R2 to R13 |

## Verification
A corrupted phase or nibble count shows at the ports as a strobe on the wrong clock. Because of that, the bench records the clock index of each strobe and compares the spacing between addr_valid, data_valid and done against the fixed distances for reads and writes. A wrong start code, cycle kind or SYNC decision shows on the same clock as a missing cyc_valid, or as the wrong warn bit. A monitor stuck in a phase shows within a few clocks, when it strobes during stimulus that an idle monitor must ignore. A miscounted wait shows on the exact clock where warn[5] is or is not expected.

// File: rtl/lpcmon_pkg.sv
package lpcmon_pkg;
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_START,
      PH_ADDR,
      PH_DATA,
      PH_TAR,
      PH_SYNC
   } phase_e;

   localparam int WARN_N    = 7;
   localparam int W_LADCHG  = 0;
   localparam int W_BADCT   = 1;
   localparam int W_UNSUP   = 2;
   localparam int W_TAR     = 3;
   localparam int W_SYNC    = 4;
   localparam int W_TMO     = 5;
   localparam int W_RESTART = 6;

   localparam logic [3:0] NIB_IDLE_BUS = 4'hF;
   localparam logic [3:0] START_TARGET = 4'h0;
   localparam logic [3:0] SYNC_READY   = 4'h0;
   localparam logic [3:0] SYNC_SHORT   = 4'h5;
   localparam logic [3:0] SYNC_LONG    = 4'h6;
endpackage

// File: rtl/lpcmon_field_accum.sv
module lpcmon_field_accum #(
   parameter int W         = 8,
   parameter bit LSN_FIRST = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         shift,
   input  logic [3:0]   nib,
   output logic [W-1:0] val
);
   if (W < 8 || (W % 4) != 0) begin : g_bad_w
      $error("lpcmon_field_accum: W must be a multiple of 4 and at least 8");
   end

   if (LSN_FIRST) begin : g_lsn
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     val <= '0;
         else if (clr)   val <= '0;
         else if (shift) val <= {nib, val[W-1:4]};
      end
   end else begin : g_msn
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     val <= '0;
         else if (clr)   val <= '0;
         else if (shift) val <= {val[W-5:0], nib};
      end
   end
endmodule

// File: rtl/lpcmon_wait_timer.sv
module lpcmon_wait_timer #(
   parameter int LIMIT = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic tick,
   output logic hit
);
   localparam int CW = $clog2(LIMIT + 1);

   if (LIMIT < 2) begin : g_bad_limit
      $error("lpcmon_wait_timer: LIMIT must be at least 2");
   end

   logic [CW-1:0] cnt;

   assign hit = tick && (cnt == CW'(LIMIT - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (clr)  cnt <= '0;
      else if (tick) cnt <= hit ? '0 : cnt + 1'b1;
   end

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt < CW'(LIMIT)); // R11
endmodule

// File: rtl/lpcmon_seq.sv
module lpcmon_seq
   import lpcmon_pkg::*;
#(
   parameter int IO_NIBS  = 4,
   parameter int MEM_NIBS = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_n,
   input  logic [3:0]        lad,
   input  logic              wait_hit,
   output logic              addr_clr,
   output logic              addr_shift,
   output logic              data_shift,
   output logic              wait_tick,
   output logic              cyc_valid,
   output logic              cyc_mem,
   output logic              cyc_wr,
   output logic              addr_valid,
   output logic              data_valid,
   output logic              done,
   output logic [WARN_N-1:0] warn
);
   localparam int CNT_W = $clog2(MEM_NIBS);

   phase_e           ph;
   logic [3:0]       start_code;
   logic [CNT_W-1:0] nib_left;
   logic             tar_hi;
   logic             tar_last;
   logic             data_hi;

   logic is_wait_code;
   assign is_wait_code = (lad == SYNC_SHORT) || (lad == SYNC_LONG);

   always_comb begin
      addr_clr   = (ph == PH_START) && frame_n;
      addr_shift = (ph == PH_ADDR)  && frame_n;
      data_shift = (ph == PH_DATA)  && frame_n;
      wait_tick  = (ph == PH_SYNC)  && frame_n && is_wait_code;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph         <= PH_IDLE;
         start_code <= '0;
         nib_left   <= '0;
         tar_hi     <= 1'b0;
         tar_last   <= 1'b0;
         data_hi    <= 1'b0;
         cyc_valid  <= 1'b0;
         cyc_mem    <= 1'b0;
         cyc_wr     <= 1'b0;
         addr_valid <= 1'b0;
         data_valid <= 1'b0;
         done       <= 1'b0;
         warn       <= '0;
      end else begin
         cyc_valid  <= 1'b0;
         addr_valid <= 1'b0;
         data_valid <= 1'b0;
         done       <= 1'b0;
         warn       <= '0;
         unique case (ph)
            PH_IDLE: begin
               if (!frame_n) begin
                  start_code <= lad;
                  ph         <= PH_START;
               end
            end
            PH_START: begin
               if (!frame_n) begin
                  if (lad != start_code) warn[W_LADCHG] <= 1'b1;
                  start_code <= lad;
               end else if (start_code != START_TARGET) begin
                  warn[W_UNSUP] <= 1'b1;
                  ph            <= PH_IDLE;
               end else if (lad[0] || (lad[3:2] == 2'b11)) begin
                  warn[W_BADCT] <= 1'b1;
                  ph            <= PH_IDLE;
               end else if (lad[3:2] == 2'b10) begin
                  warn[W_UNSUP] <= 1'b1;
                  ph            <= PH_IDLE;
               end else begin
                  cyc_valid <= 1'b1;
                  cyc_mem   <= lad[2];
                  cyc_wr    <= lad[1];
                  nib_left  <= lad[2] ? CNT_W'(MEM_NIBS - 1) : CNT_W'(IO_NIBS - 1);
                  ph        <= PH_ADDR;
               end
            end
            default: begin
               if (!frame_n) begin
                  warn[W_RESTART] <= 1'b1;
                  start_code      <= lad;
                  ph              <= PH_START;
               end else begin
                  unique case (ph)
                     PH_ADDR: begin
                        if (nib_left == '0) begin
                           addr_valid <= 1'b1;
                           data_hi    <= 1'b0;
                           tar_hi     <= 1'b0;
                           tar_last   <= 1'b0;
                           ph         <= cyc_wr ? PH_DATA : PH_TAR;
                        end else begin
                           nib_left <= nib_left - 1'b1;
                        end
                     end
                     PH_DATA: begin
                        if (!data_hi) begin
                           data_hi <= 1'b1;
                        end else begin
                           data_valid <= 1'b1;
                           tar_hi     <= 1'b0;
                           tar_last   <= !cyc_wr;
                           ph         <= PH_TAR;
                        end
                     end
                     PH_TAR: begin
                        if (lad != NIB_IDLE_BUS) warn[W_TAR] <= 1'b1;
                        if (!tar_hi) begin
                           tar_hi <= 1'b1;
                        end else if (tar_last) begin
                           done <= 1'b1;
                           ph   <= PH_IDLE;
                        end else begin
                           ph <= PH_SYNC;
                        end
                     end
                     PH_SYNC: begin
                        if (lad == SYNC_READY) begin
                           tar_hi   <= 1'b0;
                           tar_last <= 1'b1;
                           data_hi  <= 1'b0;
                           ph       <= cyc_wr ? PH_TAR : PH_DATA;
                        end else if (is_wait_code) begin
                           if (wait_hit) begin
                              warn[W_TMO] <= 1'b1;
                              ph          <= PH_IDLE;
                           end
                        end else begin
                           warn[W_SYNC] <= 1'b1;
                           ph           <= PH_IDLE;
                        end
                     end
                     default: ph <= PH_IDLE;
                  endcase
               end
            end
         endcase
      end
   end

   AST_ADDR_FRAME_HI: assert property (@(posedge clk) disable iff (!rst_n)
      addr_valid |-> $past(frame_n)); // R6
   AST_LADCHG_FRAME_LO: assert property (@(posedge clk) disable iff (!rst_n)
      warn[W_LADCHG] |-> !$past(frame_n)); // R3
   AST_TAR_FLAG_LAD: assert property (@(posedge clk) disable iff (!rst_n)
      warn[W_TAR] |-> ($past(lad) != NIB_IDLE_BUS)); // R9
   AST_RESTART_FRAME_LO: assert property (@(posedge clk) disable iff (!rst_n)
      warn[W_RESTART] |-> !$past(frame_n)); // R13
   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cyc_valid, addr_valid, data_valid, done})); // R7
   AST_SYNC_BAD_LAD: assert property (@(posedge clk) disable iff (!rst_n)
      warn[W_SYNC] |-> ($past(lad) != SYNC_READY)); // R10
endmodule

// File: rtl/lpc_txn_monitor.sv
module lpc_txn_monitor
   import lpcmon_pkg::*;
#(
   parameter int IO_ADDR_NIBS    = 4,
   parameter int MEM_ADDR_NIBS   = 8,
   parameter int SYNC_WAIT_LIMIT = 8,
   parameter int DATA_W          = 8
) (
   input  logic                       lclk,
   input  logic                       rst_n,
   input  logic                       frame_n,
   input  logic [3:0]                 lad,
   output logic                       cyc_valid,
   output logic                       cyc_mem,
   output logic                       cyc_wr,
   output logic                       addr_valid,
   output logic [MEM_ADDR_NIBS*4-1:0] addr,
   output logic                       data_valid,
   output logic [DATA_W-1:0]          data,
   output logic                       done,
   output logic [WARN_N-1:0]          warn
);
   localparam int ADDR_W = MEM_ADDR_NIBS * 4;

   if (IO_ADDR_NIBS < 1 || IO_ADDR_NIBS > MEM_ADDR_NIBS) begin : g_bad_io
      $error("lpc_txn_monitor: IO_ADDR_NIBS must lie in 1..MEM_ADDR_NIBS");
   end
   if (MEM_ADDR_NIBS < 2) begin : g_bad_mem
      $error("lpc_txn_monitor: MEM_ADDR_NIBS must be at least 2");
   end
   if (DATA_W != 8) begin : g_bad_data
      $error("lpc_txn_monitor: the data phase carries exactly one byte");
   end

   logic addr_clr, addr_shift, data_shift, wait_tick, wait_hit;

   lpcmon_seq #(
      .IO_NIBS  (IO_ADDR_NIBS),
      .MEM_NIBS (MEM_ADDR_NIBS)
   ) u_seq (
      .clk        (lclk),
      .rst_n      (rst_n),
      .frame_n    (frame_n),
      .lad        (lad),
      .wait_hit   (wait_hit),
      .addr_clr   (addr_clr),
      .addr_shift (addr_shift),
      .data_shift (data_shift),
      .wait_tick  (wait_tick),
      .cyc_valid  (cyc_valid),
      .cyc_mem    (cyc_mem),
      .cyc_wr     (cyc_wr),
      .addr_valid (addr_valid),
      .data_valid (data_valid),
      .done       (done),
      .warn       (warn)
   );

   lpcmon_field_accum #(.W(ADDR_W), .LSN_FIRST(1'b0)) u_addr_acc (
      .clk   (lclk),
      .rst_n (rst_n),
      .clr   (addr_clr),
      .shift (addr_shift),
      .nib   (lad),
      .val   (addr)
   );

   lpcmon_field_accum #(.W(DATA_W), .LSN_FIRST(1'b1)) u_data_acc (
      .clk   (lclk),
      .rst_n (rst_n),
      .clr   (addr_clr),
      .shift (data_shift),
      .nib   (lad),
      .val   (data)
   );

   lpcmon_wait_timer #(.LIMIT(SYNC_WAIT_LIMIT)) u_wait (
      .clk   (lclk),
      .rst_n (rst_n),
      .clr   (!wait_tick),
      .tick  (wait_tick),
      .hit   (wait_hit)
   );

   AST_TMO_FLAG: assert property (@(posedge lclk) disable iff (!rst_n)
      wait_hit |=> warn[W_TMO]); // R11
   AST_TMO_ONLY_ON_HIT: assert property (@(posedge lclk) disable iff (!rst_n)
      warn[W_TMO] |-> $past(wait_hit)); // R11
endmodule

// File: tb/lpc_txn_monitor_tb.sv
module lpc_txn_monitor_tb;
   logic        lclk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frame_n = 1'b1;
   logic [3:0]  lad = 4'hF;
   logic        cyc_valid, cyc_mem, cyc_wr, addr_valid, data_valid, done;
   logic [31:0] addr;
   logic [7:0]  data;
   logic [6:0]  warn;

   int n_chk = 0, n_err = 0, step_no = 0;
   int n_cyc, n_addr, n_data, n_done, i_addr, i_data, i_done;
   logic o_mem, o_wr;
   logic [31:0] o_addr;
   logic [7:0]  o_data;
   logic [6:0]  warn_acc;
   bit finished = 0;

   always #2 lclk = ~lclk;

   lpc_txn_monitor u_dut (
      .lclk(lclk), .rst_n(rst_n), .frame_n(frame_n), .lad(lad),
      .cyc_valid(cyc_valid), .cyc_mem(cyc_mem), .cyc_wr(cyc_wr),
      .addr_valid(addr_valid), .addr(addr), .data_valid(data_valid),
      .data(data), .done(done), .warn(warn)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic obs_clear();
      n_cyc = 0; n_addr = 0; n_data = 0; n_done = 0;
      i_addr = -1; i_data = -1; i_done = -1;
      o_mem = 0; o_wr = 0; o_addr = '0; o_data = '0; warn_acc = '0;
   endtask

   task automatic step(input logic f, input logic [3:0] v);
      @(negedge lclk);
      frame_n = f;
      lad     = v;
      @(posedge lclk);
      #1;
      step_no++;
      if (cyc_valid)  begin n_cyc++;  o_mem = cyc_mem; o_wr = cyc_wr; end
      if (addr_valid) begin n_addr++; o_addr = addr; i_addr = step_no; end
      if (data_valid) begin n_data++; o_data = data; i_data = step_no; end
      if (done)       begin n_done++; i_done = step_no; end
      warn_acc |= warn;
   endtask

   task automatic send_addr(input logic mem, input logic [31:0] a);
      for (int i = (mem ? 7 : 3); i >= 0; i--) step(1'b1, a[i*4 +: 4]);
   endtask

   task automatic send_data(input logic [7:0] d);
      step(1'b1, d[3:0]);
      step(1'b1, d[7:4]);
   endtask

   task automatic xfer(input logic mem, input logic wr, input logic [31:0] a,
                       input logic [7:0] d, input int nwait, input int nstart);
      for (int i = 0; i < nstart; i++) step(1'b0, 4'h0);
      step(1'b1, {1'b0, mem, wr, 1'b0});
      send_addr(mem, a);
      if (wr) send_data(d);
      step(1'b1, 4'hF); step(1'b1, 4'hF);
      for (int i = 0; i < nwait; i++) step(1'b1, (i % 2) ? 4'h5 : 4'h6);
      step(1'b1, 4'h0);
      if (!wr) send_data(d);
      step(1'b1, 4'hF); step(1'b1, 4'hF);
   endtask

   task automatic check_xfer(input string tag, input logic mem, input logic wr,
                             input logic [31:0] a, input logic [7:0] d, input int nwait);
      chk({tag, " R4 cyc count"}, n_cyc, 1);
      chk({tag, " R4 cyc_mem"}, o_mem, mem);
      chk({tag, " R4 cyc_wr"}, o_wr, wr);
      chk({tag, " R6 address"}, o_addr, a);
      chk({tag, " R8 data"}, o_data, d);
      chk({tag, " R7 data spacing"}, i_data - i_addr, wr ? 2 : 5 + nwait);
      chk({tag, " R12 done spacing"}, i_done - i_addr, 7 + nwait);
      chk({tag, " R12 done now"}, done, 1);
      chk({tag, " R9 no warnings"}, warn_acc, 0);
   endtask

   task automatic t_reset();
      chk("R1 strobes after reset", {cyc_valid, addr_valid, data_valid, done}, 0);
      chk("R1 warn after reset", warn, 0);
   endtask

   task automatic t_idle_ignore();
      obs_clear();
      step(1'b1, 4'h0); step(1'b1, 4'h2); step(1'b1, 4'h5);
      chk("R2 idle ignores lad", n_cyc + n_addr + n_data + n_done, 0);
      chk("R2 idle no warn", warn_acc, 0);
   endtask

   task automatic t_io_read();
      obs_clear();
      xfer(1'b0, 1'b0, 32'h0000_1234, 8'hA5, 0, 1);
      check_xfer("io_read", 1'b0, 1'b0, 32'h0000_1234, 8'hA5, 0);
   endtask

   task automatic t_mem_write_waits();
      obs_clear();
      xfer(1'b1, 1'b1, 32'hDEAD_BEEF, 8'hC3, 3, 3);
      check_xfer("mem_write R2 multi start", 1'b1, 1'b1, 32'hDEAD_BEEF, 8'hC3, 3);
      obs_clear();
      xfer(1'b1, 1'b0, 32'h8000_0001, 8'h3C, 2, 1);
      check_xfer("mem_read R10 waits", 1'b1, 1'b0, 32'h8000_0001, 8'h3C, 2);
   endtask

   task automatic t_start_change();
      obs_clear();
      step(1'b0, 4'h3);
      step(1'b0, 4'h0);
      chk("R3 start change flagged", warn[0], 1);
      step(1'b1, 4'h2);
      chk("R2 last start code wins", cyc_valid, 1);
      send_addr(1'b0, 32'h55AA);
      send_data(8'h11);
      step(1'b1, 4'hF); step(1'b1, 4'hF); step(1'b1, 4'h0);
      step(1'b1, 4'hF); step(1'b1, 4'hF);
      chk("R12 finished after changed start", n_done, 1);
      obs_clear();
      step(1'b0, 4'h0);
      step(1'b0, 4'h2);
      chk("R3 second change flagged", warn[0], 1);
      step(1'b1, 4'h0);
      chk("R2 non-target start unsupported", warn[2], 1);
      chk("R2 no cycle on bad start", n_cyc, 0);
      step(1'b1, 4'h0); step(1'b1, 4'h1);
      chk("R2 idle after bad start", n_addr + n_data + n_done, 0);
   endtask

   task automatic t_bad_ct();
      obs_clear();
      step(1'b0, 4'h0); step(1'b1, 4'h1);
      chk("R5 cycle type bit0 reserved", warn[1], 1);
      step(1'b1, 4'h0); step(1'b1, 4'h0);
      chk("R5 idle after bad type", n_cyc + n_addr, 0);
      step(1'b0, 4'h0); step(1'b1, 4'hC);
      chk("R5 type 11 reserved", warn[1], 1);
      step(1'b0, 4'h0); step(1'b1, 4'h8);
      chk("R5 DMA unsupported", warn[2], 1);
      chk("R5 DMA no bad-type flag", warn[1], 0);
      step(1'b1, 4'h0);
      chk("R5 no cycle strobes", n_cyc + n_addr, 0);
   endtask

   task automatic t_bad_tar();
      obs_clear();
      step(1'b0, 4'h0); step(1'b1, 4'h0);
      send_addr(1'b0, 32'h0000_00F0);
      step(1'b1, 4'h7);
      chk("R9 turnaround mismatch flagged", warn[3], 1);
      step(1'b1, 4'hF);
      chk("R9 good turnaround quiet", warn[3], 0);
      step(1'b1, 4'h0);
      send_data(8'h96);
      step(1'b1, 4'hF); step(1'b1, 4'hE);
      chk("R9 second turnaround flagged", warn[3], 1);
      chk("R9 decode continues", {n_data[3:0], o_data, n_done[3:0]}, {4'd1, 8'h96, 4'd1});
   endtask

   task automatic t_bad_sync();
      obs_clear();
      step(1'b0, 4'h0); step(1'b1, 4'h2);
      send_addr(1'b0, 32'h0000_0080);
      send_data(8'h42);
      step(1'b1, 4'hF); step(1'b1, 4'hF);
      step(1'b1, 4'hA);
      chk("R10 bad sync flagged", warn[4], 1);
      step(1'b1, 4'hF); step(1'b1, 4'hF); step(1'b1, 4'h0);
      chk("R10 idle after bad sync", n_done, 0);
   endtask

   task automatic t_timeout();
      obs_clear();
      step(1'b0, 4'h0); step(1'b1, 4'h0);
      send_addr(1'b0, 32'h0000_0001);
      step(1'b1, 4'hF); step(1'b1, 4'hF);
      for (int i = 0; i < 7; i++) step(1'b1, 4'h6);
      chk("R11 limit minus one accepted", warn_acc, 0);
      step(1'b1, 4'h6);
      chk("R11 timeout at limit", warn[5], 1);
      step(1'b1, 4'h0); step(1'b1, 4'h1); step(1'b1, 4'h2);
      chk("R11 idle after timeout", n_data, 0);
      obs_clear();
      xfer(1'b0, 1'b0, 32'h0000_7777, 8'h5A, 7, 1);
      check_xfer("R11 seven waits", 1'b0, 1'b0, 32'h0000_7777, 8'h5A, 7);
   endtask

   task automatic t_restart();
      obs_clear();
      step(1'b0, 4'h0); step(1'b1, 4'h4);
      step(1'b1, 4'h1); step(1'b1, 4'h2);
      step(1'b0, 4'h0);
      chk("R13 restart flagged", warn[6], 1);
      chk("R13 no address from cut cycle", n_addr, 0);
      obs_clear();
      step(1'b1, 4'h2);
      send_addr(1'b0, 32'h0000_BEEF);
      send_data(8'h77);
      step(1'b1, 4'hF); step(1'b1, 4'hF); step(1'b1, 4'h0);
      step(1'b1, 4'hF); step(1'b1, 4'hF);
      check_xfer("R13 new cycle", 1'b0, 1'b1, 32'h0000_BEEF, 8'h77, 0);
   endtask

   initial begin
      obs_clear();
      repeat (3) @(posedge lclk);
      #1;
      t_reset();
      @(negedge lclk);
      rst_n = 1'b1;
      t_idle_ignore();
      t_io_read();
      t_mem_write_waits();
      t_start_change();
      t_bad_ct();
      t_bad_tar();
      t_bad_sync();
      t_timeout();
      t_restart();
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge lclk);
      if (!finished) begin
         finished = 1;
         n_chk++;
         n_err++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule